// File: doc/BRIEF.md
# Channel-Group Control and Power Sequencer

This block holds the control byte for one group of two echo-canceller channels (A and B) and their tone detectors. A host writes and reads the byte over a single-register bus. The byte selects the companding law and the PCM coding for both channels, masks each channel's tone-detector interrupt, and sets the group's power state. The arithmetic datapaths sit outside the block. They take their enable, initialise and bypass controls from it, and they hand their processed samples back to it.

With the group powered down, the block routes the receive and send PCM streams around the processing. Each stream passes through a delay line that is clocked by the frame strobe, and the samples come out unchanged two frames late. When the power bit goes from 0 to 1, the block raises an initialise window that lasts two frame strobes. During that window the channel datapaths preset their registers and clear their filter coefficients. When the power bit goes from 1 to 0, any pending window is cancelled and the group returns to bypass.

Top module: `chan_group_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `ch_en_o` is 0, `bypass_o` is 1, `init_o` is 0, and both PCM outputs are 0.
- R2: A write stores `wdata_i[4:0]`: bit 0 is power, bit 1 is law, bit 2 is format, bit 3 masks tone interrupt A, bit 4 masks tone interrupt B. Bits 7:5 ignore writes and always read as 0 on `rdata_o`.
- R3: `alaw_o` follows bit 1 (1 means A-law, 0 means mu-law). `g711_o` follows bit 2 (1 means G.711 coding, 0 means sign-magnitude). Both apply to the two channels together.
- R4: `irq_a_o` equals `tone_a_i` when bit 3 is 0, and is 0 when bit 3 is 1. `irq_b_o` behaves the same way with `tone_b_i` and bit 4. The mask only gates the interrupt output; the detectors keep running while the group is powered.
- R5: While bit 0 is 0, after each frame strobe `rout_o` and `sout_o` show the values that `rin_i` and `sin_i` had at the strobe two strobes earlier. Between strobes the outputs hold.
- R6: While bit 0 is 1, `rout_o` and `sout_o` pass `proc_rout_i` and `proc_sout_i` through.
- R7: A write that takes bit 0 from 0 to 1 sets `init_o` in the next cycle. `init_o` stays high until the cycle after the second frame strobe that follows the write. A strobe in the same cycle as the write is not counted.
- R8: A write that keeps bit 0 at 1 while `init_o` is high neither restarts nor extends the window.
- R9: A write that takes bit 0 from 1 to 0 clears `init_o` in the next cycle.
- R10: `ch_en_o` equals bit 0 and `bypass_o` is its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle frame strobe |
| wr_i | input | 1 | Register write enable |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| rin_i | input | DATA_W | Receive-direction PCM in |
| sin_i | input | DATA_W | Send-direction PCM in |
| proc_rout_i | input | DATA_W | Processed receive sample from the datapath |
| proc_sout_i | input | DATA_W | Processed send sample from the datapath |
| rout_o | output | DATA_W | Receive-direction PCM out |
| sout_o | output | DATA_W | Send-direction PCM out |
| tone_a_i | input | 1 | Tone-detector event, channel A |
| tone_b_i | input | 1 | Tone-detector event, channel B |
| irq_a_o | output | 1 | Masked tone interrupt, channel A |
| irq_b_o | output | 1 | Masked tone interrupt, channel B |
| ch_en_o | output | 1 | Enable for the channel datapaths and tone detectors |
| init_o | output | 1 | Initialise window active (busy) |
| bypass_o | output | 1 | Power-down bypass active |
| alaw_o | output | 1 | Law select for both channels |
| g711_o | output | 1 | Coding format select for both channels |

## Verification
The bench builds the block with its defaults: 8-bit samples, a two-frame initialise window and a two-frame bypass delay. With those values every strobe count the requirements name is reached within a few dozen cycles. Frame strobes arrive every five cycles. This lets writes land inside the initialise window, between strobes, and in the same cycle as a strobe. It also lets the delay-line contents be traced sample by sample against a queue.

// File: rtl/chan_group_pkg.sv
package chan_group_pkg;
  typedef struct packed {
    logic mask_b;
    logic mask_a;
    logic fmt;
    logic law;
    logic pwr;
  } ctrl_t;
  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import chan_group_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_o,
  output logic       rise_o,
  output logic       fall_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_i) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  assign rise_o = wr_i &  wdata_i[0] & ~ctrl_q.pwr;
  assign fall_o = wr_i & ~wdata_i[0] &  ctrl_q.pwr;
  assign ctrl_o = ctrl_q;

  p_pwr_follows_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ctrl_q.pwr == $past(wdata_i[0]));
endmodule

// File: rtl/init_seq.sv
module init_seq #(
  parameter int INIT_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic frame_i,
  input  logic pwr_i,
  output logic busy_o
);
  localparam int CNT_W = (INIT_FRAMES > 1) ? $clog2(INIT_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_FRAMES - 1);

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (rise_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (fall_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q && frame_i) begin
      if (cnt_q == LAST) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = act_q;

  p_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> act_q && cnt_q == '0);
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> !act_q);
  p_busy_needs_pwr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> pwr_i);
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q && !rise_i && !fall_i && !frame_i |=> act_q && $stable(cnt_q));
endmodule

// File: rtl/frame_delay.sv
module frame_delay #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  localparam int STAGES = DEPTH + 1;

  logic [STAGES-1:0][DATA_W-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else if (frame_i) stage_q[g] <= (g == 0) ? din_i : stage_q[(g == 0) ? 0 : g-1];
    end
  end

  assign dout_o = stage_q[STAGES-1];

  p_hold_between_frames_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(dout_o));
endmodule

// File: rtl/chan_group_ctrl.sv
module chan_group_ctrl
  import chan_group_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int INIT_FRAMES  = 2,
  parameter int DELAY_FRAMES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [DATA_W-1:0] rin_i,
  input  logic [DATA_W-1:0] sin_i,
  input  logic [DATA_W-1:0] proc_rout_i,
  input  logic [DATA_W-1:0] proc_sout_i,
  output logic [DATA_W-1:0] rout_o,
  output logic [DATA_W-1:0] sout_o,
  input  logic              tone_a_i,
  input  logic              tone_b_i,
  output logic              irq_a_o,
  output logic              irq_b_o,
  output logic              ch_en_o,
  output logic              init_o,
  output logic              bypass_o,
  output logic              alaw_o,
  output logic              g711_o
);
  localparam int N_DIR = 2;

  ctrl_t ctrl;
  logic  rise, fall;

  ctrl_reg i_ctrl_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .wdata_i(wdata_i),
    .ctrl_o (ctrl),
    .rise_o (rise),
    .fall_o (fall)
  );

  init_seq #(.INIT_FRAMES(INIT_FRAMES)) i_init_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .fall_i (fall),
    .frame_i(frame_i),
    .pwr_i  (ctrl.pwr),
    .busy_o (init_o)
  );

  logic [N_DIR-1:0][DATA_W-1:0] dly_in, dly_out, proc_in, pcm_out;
  assign dly_in  = {sin_i, rin_i};
  assign proc_in = {proc_sout_i, proc_rout_i};

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    frame_delay #(.DATA_W(DATA_W), .DEPTH(DELAY_FRAMES)) i_frame_delay (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .frame_i(frame_i),
      .din_i  (dly_in[d]),
      .dout_o (dly_out[d])
    );
    assign pcm_out[d] = ctrl.pwr ? proc_in[d] : dly_out[d];
  end

  assign rout_o   = pcm_out[0];
  assign sout_o   = pcm_out[1];
  assign rdata_o  = {{(8-CTRL_W){1'b0}}, ctrl};
  assign ch_en_o  = ctrl.pwr;
  assign bypass_o = ~ctrl.pwr;
  assign alaw_o   = ctrl.law;
  assign g711_o   = ctrl.fmt;
  assign irq_a_o  = tone_a_i & ~ctrl.mask_a;
  assign irq_b_o  = tone_b_i & ~ctrl.mask_b;

  p_bypass_no_init_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_o |-> !init_o);
  p_masked_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[3] |-> !irq_a_o);
endmodule

// File: tb/test_chan_group_ctrl.sv
module test_chan_group_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [DW-1:0] rin = '0, sin = '0, prr = '0, prs = '0, rout, sout;
  logic tone_a = 1'b0, tone_b = 1'b0;
  logic irq_a, irq_b, ch_en, init, bypass, alaw, g711;

  int checks = 0, errors = 0;
  int cyc = 0;

  // reference model state
  int m_reg = 0;
  bit m_act = 0;
  int m_cnt = 0;
  int q_r[$];
  int q_s[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_group_ctrl i_chan_group_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .rin_i(rin), .sin_i(sin), .proc_rout_i(prr), .proc_sout_i(prs),
    .rout_o(rout), .sout_o(sout), .tone_a_i(tone_a), .tone_b_i(tone_b),
    .irq_a_o(irq_a), .irq_b_o(irq_b), .ch_en_o(ch_en), .init_o(init),
    .bypass_o(bypass), .alaw_o(alaw), .g711_o(g711)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0; m_act = 0; m_cnt = 0;
      q_r = '{0, 0, 0};
      q_s = '{0, 0, 0};
    end else begin
      cyc++;
      if (wr && wdata[0] && !m_reg[0]) begin
        m_act = 1; m_cnt = 0;
      end else if (wr && !wdata[0] && m_reg[0]) begin
        m_act = 0; m_cnt = 0;
      end else if (frame && m_act) begin
        m_cnt++;
        if (m_cnt == 2) begin m_act = 0; m_cnt = 0; end
      end
      if (wr) m_reg = wdata & 8'h1f;
      if (frame) begin
        q_r.push_back(rin); void'(q_r.pop_front());
        q_s.push_back(sin); void'(q_s.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 rdata", rdata, m_reg);
      chk("R3 alaw", alaw, m_reg[1]);
      chk("R3 g711", g711, m_reg[2]);
      chk("R4 irq_a", irq_a, tone_a & !m_reg[3]);
      chk("R4 irq_b", irq_b, tone_b & !m_reg[4]);
      if (m_reg[0]) begin
        chk("R6 rout", rout, prr);
        chk("R6 sout", sout, prs);
      end else begin
        chk("R5 rout", rout, q_r[0]);
        chk("R5 sout", sout, q_s[0]);
      end
      chk("R7 R8 R9 init", init, m_act);
      chk("R10 ch_en", ch_en, m_reg[0]);
      chk("R10 bypass", bypass, !m_reg[0]);
    end
  end

  task automatic step(input bit w, input logic [7:0] d, input bit f);
    @(posedge clk); #1;
    wr = w; wdata = d; frame = f;
    rin = DW'($urandom); sin = DW'($urandom);
    prr = DW'($urandom); prs = DW'($urandom);
    tone_a = 1'($urandom); tone_b = 1'($urandom);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 8'h00, (cyc % 5) == 4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 rdata", rdata, 0);
    chk("R1 ch_en", ch_en, 0);
    chk("R1 bypass", bypass, 1);
    chk("R1 init", init, 0);
    chk("R1 rout", rout, 0);
    chk("R1 sout", sout, 0);
    run(20);
    step(1'b1, 8'hFE, 1'b0);   // upper bits ignored, stays powered down
    run(20);
    step(1'b1, 8'h01, 1'b0);   // power up
    run(16);
    step(1'b1, 8'h00, 1'b0);
    run(4);
    step(1'b1, 8'h01, 1'b0);
    run(3);
    step(1'b1, 8'h07, 1'b0);   // R8: no restart
    run(3);
    step(1'b1, 8'h06, 1'b0);   // R9: abort
    run(6);
    step(1'b1, 8'h19, 1'b1);   // R7: edge with strobe in same cycle
    run(16);
    step(1'b1, 8'h00, 1'b0);
    run(20);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule